// File: doc/BRIEF.md
# Chunked JTAG Scan Engine

This block drives a JTAG test port for one instruction-register (IR) or data-register (DR) scan of any length from 1 to 65535 bits. It produces TCK from the system clock with a programmable divider and sequences TMS to walk the target's TAP controller. It moves the TAP into the shift state from either Run-Test/Idle or a pause state. It shifts the scan bits and parks the TAP in the matching pause state. From there it either stays paused or returns to idle.

Scan data is exchanged one 32-bit word at a time. A scan longer than 32 bits stops in the pause state after every full chunk. There the host reads the captured word, writes the next outgoing word and strobes continue. The engine then resumes shifting through Exit2. Progress is reported through a status word that holds separate pause and complete flags for IR and DR scans. Each flag is cleared by writing 1 to it, and each has an interrupt enable.

Top module: `jtag_chunk_scan`

## Requirements
- R1: After reset tck, busy, irq, rdata and the whole status word are 0.
- R2: Starting with the TAP in idle, an IR scan sends TMS 1,1,0,0 before its first data bit and a DR scan sends TMS 1,0,0.
- R3: When the previous scan ended paused, a new scan first sends TMS 1,1 and then the R2 prefix.
- R4: Data bits are sent LSB first, one per TCK rising edge. TMS is 0 on every bit of a chunk except the last, where it is 1. One more TCK with TMS 0 follows, which enters the pause state. TMS and TDI never change while TCK is high.
- R5: A scan ending in idle sends TMS 1,1,0 after entering pause, then drops busy.
- R6: In a read scan TDI is 1 on every data bit.
- R7: Chunks hold 32 bits. After each full chunk with bits left, the engine keeps busy high and stops TCK in pause until continue is strobed. It then sends TMS 1,0 and shifts the word present on wdata at the strobe.
- R8: When the engine stops, rdata holds the TDO bits of the chunk just shifted, with the first bit in bit 0. A chunk of n < 32 bits is right-aligned, and bits above n-1 are 0.
- R9: Status bit 19 is IR pause, 18 is IR complete, 17 is DR pause and 16 is DR complete. A pause flag is set when the engine stops in pause (between chunks or at a paused end). A complete flag is set when the TAP reaches idle. A scan ending in idle does not set its pause flag.
- R10: A status write with bit k (19..16) set clears that flag. Bits 3..0 of the same write load the enables for flags 19..16 in that order. Status bits 3..0 read back the enables, and irq is 1 exactly when some flag and its enable are both 1.
- R11: A start with length 0 is ignored: busy stays 0 and no TCK edge occurs.
- R12: While running, TCK stays high for tck_div+1 clock cycles and low for tck_div+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tck_div | input | 8 | TCK half-period minus one, in clock cycles |
| start | input | 1 | Begin a scan (taken only while not busy) |
| scan_ir | input | 1 | 1 = IR scan, 0 = DR scan |
| read_scan | input | 1 | 1 = drive TDI high instead of data |
| end_pause | input | 1 | 1 = finish in pause, 0 = finish in idle |
| scan_len | input | 16 | Total bit count of the scan |
| cont | input | 1 | Resume after a chunk stop |
| wdata | input | 32 | Outgoing chunk word, taken at start or continue |
| rdata | output | 32 | Captured TDO bits of the last chunk |
| busy | output | 1 | Scan in progress, including chunk stops |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 32 | Status write data (W1C flags, enables) |
| sts_rdata | output | 32 | Status word: flags 19..16, enables 3..0 |
| irq | output | 1 | Interrupt request |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to target |
| tdo | input | 1 | Test data from target |

## Verification
The bench records TMS, TDI and TDO at every TCK rising edge and rebuilds the expected walk for each scan from its kind, start point and end point. An engine that skipped the Exit2/Update prefix after a paused end, or used the IR walk for DR, shows up as a TMS mismatch. Scans of exactly 32 bits and of 70 bits split 32/32/6 catch off-by-one chunk counts, a missing stop, and a final word left unaligned or filled with stale bits. Flag tests confirm that the pause flag does not fire on a pass-through to idle, that a W1C write clears only its own flag, and that irq follows the enable mask.

// File: rtl/jscan_pkg.sv
package jscan_pkg;
  localparam int CHUNK_W = 32;
  localparam int CNT_W   = $clog2(CHUNK_W) + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SEL, ST_SHIFT, ST_PAUSE_IN, ST_WAIT, ST_RESUME, ST_TO_IDLE
  } scan_state_e;

  // Bits in the next chunk: the rest of the scan, capped at one word.
  function automatic logic [CNT_W-1:0] chunk_len(input int unsigned remain);
    if (remain > CHUNK_W) return CNT_W'(CHUNK_W);
    return CNT_W'(remain);
  endfunction

  // Captured bits enter at the MSB; move a short chunk down to bit 0.
  function automatic logic [CHUNK_W-1:0] right_align(input logic [CHUNK_W-1:0] cap,
                                                     input logic [CNT_W-1:0] nbits);
    if (nbits == 0 || int'(nbits) >= CHUNK_W) return cap;
    return cap >> (CHUNK_W - int'(nbits));
  endfunction

  // TMS walk from idle/update to the shift state.
  function automatic logic sel_tms(input logic is_ir, input logic [1:0] step);
    return is_ir ? (step < 2'd2) : (step == 2'd0);
  endfunction
endpackage

// File: rtl/jscan_tck_gen.sv
module jscan_tck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tck,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick = run && (cnt == div);
  assign rise = tick && !tck;
  assign fall = tick && tck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      tck <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      tck <= !tck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/jscan_seq.sv
module jscan_seq
  import jscan_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               scan_ir,
  input  logic               read_scan,
  input  logic               end_pause,
  input  logic [LEN_W-1:0]   scan_len,
  input  logic               cont,
  input  logic [CHUNK_W-1:0] wdata,
  input  logic               tdo,
  input  logic               rise,
  input  logic               fall,
  output logic               tms,
  output logic               tdi,
  output logic               run,
  output logic               busy,
  output logic               shift_bit,
  output logic               ir_sel,
  output logic               rd_sel,
  output logic               ev_pause,
  output logic               ev_done,
  output logic [CHUNK_W-1:0] rdata
);
  scan_state_e        state;
  logic [1:0]         step;
  logic [LEN_W-1:0]   rem;
  logic [CNT_W-1:0]   nb, bitcnt;
  logic [CHUNK_W-1:0] shreg, cap;
  logic               ir_q, rd_q, endp_q, in_pause;
  logic               last_bit, start_ok;
  logic [1:0]         sel_last;

  assign last_bit  = (bitcnt == nb - 1'b1);
  assign start_ok  = start && (scan_len != '0);
  assign sel_last  = ir_q ? 2'd3 : 2'd2;
  assign busy      = (state != ST_IDLE);
  assign run       = busy && (state != ST_WAIT);
  assign shift_bit = (state == ST_SHIFT);
  assign ir_sel    = ir_q;
  assign rd_sel    = rd_q;
  assign ev_pause  = fall && (state == ST_PAUSE_IN) && ((rem != '0) || endp_q);
  assign ev_done   = fall && (state == ST_TO_IDLE) && (step == 2'd2);
  assign tdi       = (shift_bit && !rd_q) ? shreg[0] : 1'b1;

  always_comb begin
    case (state)
      ST_PRE:     tms = 1'b1;
      ST_SEL:     tms = sel_tms(ir_q, step);
      ST_SHIFT:   tms = last_bit;
      ST_RESUME:  tms = (step == 2'd0);
      ST_TO_IDLE: tms = (step != 2'd2);
      default:    tms = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step     <= '0;
      rem      <= '0;
      nb       <= '0;
      bitcnt   <= '0;
      shreg    <= '0;
      cap      <= '0;
      rdata    <= '0;
      ir_q     <= 1'b0;
      rd_q     <= 1'b0;
      endp_q   <= 1'b0;
      in_pause <= 1'b0;
    end else begin
      if (rise && shift_bit) cap <= {tdo, cap[CHUNK_W-1:1]};
      case (state)
        ST_IDLE: if (start_ok) begin
          ir_q   <= scan_ir;
          rd_q   <= read_scan;
          endp_q <= end_pause;
          rem    <= scan_len;
          nb     <= chunk_len(int'(scan_len));
          shreg  <= wdata;
          bitcnt <= '0;
          step   <= '0;
          state  <= in_pause ? ST_PRE : ST_SEL;
        end
        ST_PRE: if (fall) begin
          if (step == 2'd1) begin step <= '0; state <= ST_SEL; end
          else step <= step + 1'b1;
        end
        ST_SEL: if (fall) begin
          if (step == sel_last) begin step <= '0; state <= ST_SHIFT; end
          else step <= step + 1'b1;
        end
        ST_SHIFT: if (fall) begin
          shreg  <= shreg >> 1;
          bitcnt <= bitcnt + 1'b1;
          if (last_bit) begin
            rem   <= rem - LEN_W'(nb);
            rdata <= right_align(cap, nb);
            state <= ST_PAUSE_IN;
          end
        end
        ST_PAUSE_IN: if (fall) begin
          if (rem != '0) state <= ST_WAIT;
          else if (endp_q) begin state <= ST_IDLE; in_pause <= 1'b1; end
          else begin step <= '0; state <= ST_TO_IDLE; end
        end
        ST_WAIT: if (cont) begin
          shreg  <= wdata;
          nb     <= chunk_len(int'(rem));
          bitcnt <= '0;
          step   <= '0;
          state  <= ST_RESUME;
        end
        ST_RESUME: if (fall) begin
          if (step == 2'd1) begin step <= '0; state <= ST_SHIFT; end
          else step <= step + 1'b1;
        end
        ST_TO_IDLE: if (fall) begin
          if (step == 2'd2) begin state <= ST_IDLE; in_pause <= 1'b0; step <= '0; end
          else step <= step + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/jscan_irq_regs.sv
module jscan_irq_regs #(
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_flags,
  input  logic             wr,
  input  logic [NFLAG-1:0] wr_clear,
  input  logic [NFLAG-1:0] wr_enable,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] enables,
  output logic             irq
);
  logic [NFLAG-1:0] clr;

  assign clr = wr ? wr_clear : '0;
  assign irq = |(flags & enables);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      enables <= '0;
    end else begin
      flags <= (flags & ~clr) | set_flags;
      if (wr) enables <= wr_enable;
    end
  end
endmodule

// File: rtl/jtag_chunk_scan.sv
module jtag_chunk_scan
  import jscan_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   tck_div,
  input  logic               start,
  input  logic               scan_ir,
  input  logic               read_scan,
  input  logic               end_pause,
  input  logic [LEN_W-1:0]   scan_len,
  input  logic               cont,
  input  logic [CHUNK_W-1:0] wdata,
  output logic [CHUNK_W-1:0] rdata,
  output logic               busy,
  input  logic               sts_wr,
  input  logic [31:0]        sts_wdata,
  output logic [31:0]        sts_rdata,
  output logic               irq,
  output logic               tck,
  output logic               tms,
  output logic               tdi,
  input  logic               tdo
);
  localparam int NFLAG = 4;

  logic             rise, fall, run, shift_bit, ir_sel, rd_sel, ev_pause, ev_done;
  logic [NFLAG-1:0] set_flags, flags, enables;
  logic             sts_unused;

  assign sts_unused = ^{sts_wdata[31:20], sts_wdata[15:4]};
  // Order matches status bits 19..16: IR pause, IR done, DR pause, DR done.
  assign set_flags  = {ir_sel & ev_pause, ir_sel & ev_done, ~ir_sel & ev_pause, ~ir_sel & ev_done};
  assign sts_rdata  = {12'b0, flags, 12'b0, enables};

  jscan_tck_gen #(.DIV_W(DIV_W)) u_tck (
    .clk(clk), .rst_n(rst_n), .run(run), .div(tck_div),
    .tck(tck), .rise(rise), .fall(fall)
  );

  jscan_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_ir(scan_ir), .read_scan(read_scan),
    .end_pause(end_pause), .scan_len(scan_len), .cont(cont), .wdata(wdata), .tdo(tdo),
    .rise(rise), .fall(fall), .tms(tms), .tdi(tdi), .run(run), .busy(busy),
    .shift_bit(shift_bit), .ir_sel(ir_sel), .rd_sel(rd_sel), .ev_pause(ev_pause),
    .ev_done(ev_done), .rdata(rdata)
  );

  jscan_irq_regs #(.NFLAG(NFLAG)) u_regs (
    .clk(clk), .rst_n(rst_n), .set_flags(set_flags), .wr(sts_wr),
    .wr_clear(sts_wdata[19:16]), .wr_enable(sts_wdata[3:0]),
    .flags(flags), .enables(enables), .irq(irq)
  );
endmodule

// File: rtl/jtag_chunk_scan_chk.sv
module jtag_chunk_scan_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tck,
  input logic             tms,
  input logic             tdi,
  input logic             start,
  input logic [LEN_W-1:0] scan_len,
  input logic             busy,
  input logic             shift_bit,
  input logic             rd_sel,
  input logic [3:0]       set_flags,
  input logic             sts_wr,
  input logic             clr_dr_done,
  input logic             dr_done_flag
);
  p_tck_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tck);
  p_zero_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && scan_len == '0 && !busy) |=> !busy);
  p_read_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_bit && rd_sel) |-> tdi);
  p_pins_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> ($stable(tms) && $stable(tdi)));
  p_one_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_flags));
  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && clr_dr_done && !set_flags[0]) |=> !dr_done_flag);
endmodule

bind jtag_chunk_scan jtag_chunk_scan_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tck(tck), .tms(tms), .tdi(tdi),
  .start(start), .scan_len(scan_len), .busy(busy), .shift_bit(shift_bit),
  .rd_sel(rd_sel), .set_flags(set_flags), .sts_wr(sts_wr),
  .clr_dr_done(sts_wdata[16]), .dr_done_flag(sts_rdata[16])
);

// File: tb/jtag_chunk_scan_test.sv
module jtag_chunk_scan_test;
  localparam int LEN_W = 16;
  localparam int DIV_W = 8;
  localparam int LOGN  = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [DIV_W-1:0] tck_div = 8'd1;
  logic start = 0, scan_ir = 0, read_scan = 0, end_pause = 0, cont = 0, sts_wr = 0;
  logic [LEN_W-1:0] scan_len = '0;
  logic [31:0] wdata = '0, sts_wdata = '0;
  logic [31:0] rdata, sts_rdata;
  logic busy, irq, tck, tms, tdi;
  logic tdo = 1'b0;

  jtag_chunk_scan #(.LEN_W(LEN_W), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .tck_div(tck_div), .start(start), .scan_ir(scan_ir),
    .read_scan(read_scan), .end_pause(end_pause), .scan_len(scan_len), .cont(cont),
    .wdata(wdata), .rdata(rdata), .busy(busy), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .sts_rdata(sts_rdata), .irq(irq), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  int checks = 0;
  int errors = 0;
  int n = 0;
  logic tms_log[LOGN];
  logic tdi_log[LOGN];
  logic tdo_log[LOGN];

  function automatic logic tdo_fn(int k);
    return ((k * 7) % 11) > 4;
  endfunction

  // Target model: record pins at each TCK rise, then present next TDO bit.
  always @(posedge tck) begin
    if (n < LOGN) begin
      tms_log[n] = tms;
      tdi_log[n] = tdi;
      tdo_log[n] = tdo;
    end
    n = n + 1;
    tdo = tdo_fn(n);
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sts_write(logic [31:0] v);
    @(negedge clk);
    sts_wr = 1; sts_wdata = v;
    @(negedge clk);
    sts_wr = 0; sts_wdata = '0;
  endtask

  task automatic wait_bit(int b, output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (sts_rdata[b]) begin ok = 1; break; end
    end
  endtask

  task automatic do_scan(string tag, bit ir, bit rd, bit endp, int len,
                         logic [31:0] w0, logic [31:0] w1, logic [31:0] w2, bit from_pause);
    logic [31:0] words[3];
    logic exp_tms[256];
    logic exp_tdi[256];
    bit   exp_chk[256];
    int e, base, remn, c, nb, first, pbit, dbit, mt, md, n0;
    bit ok;
    logic [31:0] expw;
    words[0] = w0; words[1] = w1; words[2] = w2;
    pbit = ir ? 19 : 17;
    dbit = ir ? 18 : 16;
    e = 0;
    for (int i = 0; i < 256; i++) exp_chk[i] = 0;
    sts_write(32'h000F_0000);
    base = n;
    if (from_pause) begin exp_tms[e++] = 1; exp_tms[e++] = 1; end
    exp_tms[e++] = 1;
    if (ir) exp_tms[e++] = 1;
    exp_tms[e++] = 0; exp_tms[e++] = 0;
    @(negedge clk);
    start = 1; scan_ir = ir; read_scan = rd; end_pause = endp;
    scan_len = LEN_W'(len); wdata = w0;
    @(negedge clk);
    start = 0;
    remn = len; c = 0;
    while (remn > 0) begin
      nb = (remn > 32) ? 32 : remn;
      if (c > 0) begin exp_tms[e++] = 1; exp_tms[e++] = 0; end
      first = e;
      for (int j = 0; j < nb; j++) begin
        exp_tms[e] = (j == nb - 1);
        exp_tdi[e] = rd ? 1'b1 : words[c][j];
        exp_chk[e] = 1;
        e++;
      end
      exp_tms[e++] = 0;
      remn -= nb;
      if (remn == 0 && !endp) begin exp_tms[e++] = 1; exp_tms[e++] = 1; exp_tms[e++] = 0; end
      wait_bit((remn > 0 || endp) ? pbit : dbit, ok);
      chk({tag, " flag raised (R9)"}, 32'(ok), 32'd1);
      expw = '0;
      for (int j = 0; j < nb; j++) expw[j] = tdo_log[base + first + j];
      chk({tag, " right-aligned chunk rdata (R8)"}, rdata, expw);
      if (remn > 0) begin
        n0 = n;
        repeat (12) @(negedge clk);
        chk({tag, " stall in pause (R7)"}, {30'd0, busy, tck}, {30'd0, 1'b1, 1'b0});
        chk({tag, " no TCK during stall (R7)"}, 32'(n - n0), 32'd0);
        sts_write(32'h1 << pbit);
        @(negedge clk);
        cont = 1; wdata = words[c + 1];
        @(negedge clk);
        cont = 0;
      end else begin
        @(negedge clk);
        chk({tag, " busy low at end (R5)"}, 32'(busy), 32'd0);
        if (!endp) chk({tag, " no pause flag on idle end (R9)"}, 32'(sts_rdata[pbit]), 32'd0);
      end
      c++;
    end
    chk({tag, " TCK count"}, 32'(n - base), 32'(e));
    mt = 0; md = 0;
    for (int i = 0; i < e && i < 256; i++) begin
      if (tms_log[base + i] !== exp_tms[i]) mt++;
      if (exp_chk[i] && tdi_log[base + i] !== exp_tdi[i]) md++;
    end
    chk({tag, " TMS walk mismatches"}, 32'(mt), 32'd0);
    chk({tag, " TDI data mismatches"}, 32'(md), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 tck", 32'(tck), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    chk("R1 status", sts_rdata, 32'd0);
  endtask

  task automatic t_zero_len();
    int n0;
    n0 = n;
    @(negedge clk);
    start = 1; scan_len = '0; scan_ir = 0;
    @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    chk("R11 busy stays low", 32'(busy), 32'd0);
    chk("R11 no TCK edges", 32'(n - n0), 32'd0);
    chk("R11 no flags", sts_rdata, 32'd0);
  endtask

  task automatic t_tck_period();
    int hi, lo;
    bit ok;
    tck_div = 8'd2;
    sts_write(32'h000F_0000);
    @(negedge clk);
    start = 1; scan_ir = 0; read_scan = 0; end_pause = 0; scan_len = 16'd2; wdata = 32'h1;
    @(negedge clk);
    start = 0;
    @(posedge tck);
    hi = 0;
    forever begin
      @(negedge clk);
      if (tck) hi++; else break;
    end
    lo = 1;
    forever begin
      @(negedge clk);
      if (!tck) lo++; else break;
    end
    chk("R12 TCK high cycles", 32'(hi), 32'd3);
    chk("R12 TCK low cycles", 32'(lo), 32'd3);
    wait_bit(16, ok);
    chk("R12 scan completes", 32'(ok), 32'd1);
  endtask

  task automatic t_irq();
    // DR complete flag (bit 16) is set from the previous scan.
    chk("R10 DR done flag present", sts_rdata, 32'h0001_0000);
    sts_write(32'h0000_0001);
    chk("R10 irq with enable 0", 32'(irq), 32'd1);
    sts_write(32'h0000_0002);
    chk("R10 irq masked", {31'd0, irq}, 32'd0);
    chk("R10 flag kept, enable read back", sts_rdata, 32'h0001_0002);
    sts_write(32'h0001_0002);
    chk("R10 W1C clears flag", sts_rdata, 32'h0000_0002);
    sts_write(32'h0000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_zero_len();
    do_scan("R2 R4 R5 DR write 8 idle-to-idle", 0, 0, 0, 8, 32'h0000_00A5, '0, '0, 0);
    do_scan("R2 R4 R9 IR write 5 end paused", 1, 0, 1, 5, 32'h0000_0016, '0, '0, 0);
    do_scan("R3 R6 R7 DR read 40 from pause", 0, 1, 0, 40, 32'h1234_5678, 32'h0, '0, 1);
    do_scan("R2 R6 R8 IR read 32 full chunk", 1, 1, 0, 32, 32'h0, '0, '0, 0);
    tck_div = 8'd3;
    do_scan("R7 R8 DR write 70 three chunks", 0, 0, 1, 70, 32'hDEAD_BEEF, 32'h1234_5678, 32'h0000_002A, 0);
    do_scan("R3 R5 IR write 4 from pause", 1, 0, 0, 4, 32'h0000_0009, '0, '0, 1);
    tck_div = 8'd1;
    t_tck_period();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule